// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is a single 16-bit capture/compare channel together with the free-running up-counter it watches. One holding register serves two roles, and a mode input chooses the role.

In compare mode the register holds a match value written by software. A single-cycle interrupt pulse is raised each time the counter counts away from that value. In capture mode a chosen edge of an external pin copies the current counter value into the register, and each such copy raises the same pulse.

The pin is synchronised before its edges are detected. A 2-bit code picks falling, rising or both edges; the fourth code value is reserved and disables capture. Software reads the register through a plain read port and writes it through a one-cycle write strobe.

Top module: `tcc_channel`

## Requirements
- R1: After reset, the register reads 0000H, the counter reads 0000H and the interrupt output is low.
- R2: The counter increases by one on each clock where `cnt_tick` is high and `cnt_stop` is low. It wraps from FFFFH to 0000H and otherwise keeps its value.
- R3: While `cnt_stop` is high, the counter keeps its value whatever `cnt_tick` does.
- R4: In compare mode (`mode_capture` = 0), when the counter advances away from a value equal to the register, `irq` is high for exactly one cycle. That cycle is the first one in which `cnt_value` shows the next count. A counter that is held does not raise it.
- R5: A compare value of 0000H raises no interrupt on the first advance after reset (0000H to 0001H). It does raise one when the counter goes from 0000H to 0001H after wrapping from FFFFH.
- R6: A write strobe loads `wr_data` into the register at the next clock in either mode, including while the counter runs. In compare mode, the value then stays unchanged until the next write.
- R7: In capture mode (`mode_capture` = 1), `edge_sel` picks the trigger: 00 falling edge, 01 rising edge, 11 both edges, 10 no capture. A pin change is stored on the third rising clock after it, and the register receives the counter value held before that clock.
- R8: Each capture raises `irq` for exactly one cycle.
- R9: When a capture and a write strobe fall on the same clock, the register keeps the captured counter value.
- R10: Pin edges in compare mode leave the register unchanged and raise no interrupt. In capture mode, the counter passing the register value raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_tick | input | 1 | Count enable for one clock |
| cnt_stop | input | 1 | Holds the counter |
| mode_capture | input | 1 | 0 compare role, 1 capture role |
| edge_sel | input | 2 | Capture edge code (00 fall, 01 rise, 11 both, 10 none) |
| cap_pin | input | 1 | Asynchronous external trigger pin |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Current register value |
| cnt_value | output | 16 | Current counter value |
| irq | output | 1 | Single-cycle interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and a two-flop synchroniser. With these values, table vectors that run 65,537 ticks are short enough to reach the FFFFH to 0000H wrap. That brings the zero-compare and all-ones-compare corner cases of R5 into reach. The fixed three-clock pin latency lets one directed test place a write strobe exactly on the capture clock.

// File: rtl/tcc_pkg.sv
// Shared encodings of the timer capture/compare channel.
// Assumes: the edge code is 2 bits wide and decoded only inside the edge detector.
package tcc_pkg;
    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_NONE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_code_e;
endpackage

// File: rtl/tcc_free_counter.sv
// Free-running up-counter with a count enable and a stop input.
// Assumes: stop overrides the enable; the counter wraps to zero naturally.
// Also reports whether any count step has happened since reset.
module tcc_free_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         stop,
    output logic         advance,
    output logic         counted,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] count_q;
    logic         counted_q;

    // A step happens only when enabled and not stopped.
    assign advance = tick & ~stop;

    // Count register with natural wrap-around.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (advance) begin
            count_q <= count_q + ONE;
        end
    end

    // Remembers that the counter has stepped at least once since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            counted_q <= 1'b0;
        end else if (advance) begin
            counted_q <= 1'b1;
        end
    end

    assign count   = count_q;
    assign counted = counted_q;
endmodule

// File: rtl/tcc_pin_edge.sv
// Synchronises the external trigger pin and flags the selected edge.
// Assumes: STAGES >= 2; each flagged edge lasts exactly one clock.
// Code EDGE_NONE never flags anything.
module tcc_pin_edge
    import tcc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] sel,
    output logic       hit
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;
    logic             rise;
    logic             fall;

    // Synchroniser stages followed by one history flop.
    genvar g;
    generate
        for (g = 0; g < CHAIN; g++) begin : g_chain
            if (g == 0) begin : g_first
                // First stage samples the asynchronous pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= pin;
                end
            end else begin : g_next
                // Later stages shift the sampled level along.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];

    // Decode the edge code into a single trigger.
    always_comb begin
        unique case (edge_code_e'(sel))
            EDGE_FALL: hit = fall;
            EDGE_RISE: hit = rise;
            EDGE_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/tcc_cc_reg.sv
// Shared capture/compare register with interrupt generation.
// Assumes: in capture mode a capture wins over a write on the same clock.
// A compare match fires when the counter steps away from the register value,
// and only once the counter has already stepped since reset.
module tcc_cc_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_capture,
    input  logic         advance,
    input  logic         counted,
    input  logic [W-1:0] count,
    input  logic         hit,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] value,
    output logic         irq
);
    logic [W-1:0] value_q;
    logic         irq_q;
    logic         do_capture;
    logic         do_match;

    assign do_capture = mode_capture & hit;
    assign do_match   = ~mode_capture & advance & counted & (count == value_q);

    // Register update: capture first, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (do_capture) begin
            value_q <= count;
        end else if (wr_en) begin
            value_q <= wr_data;
        end
    end

    // One-cycle interrupt pulse on a capture or a compare match.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= do_capture | do_match;
    end

    assign value = value_q;
    assign irq   = irq_q;
endmodule

// File: rtl/tcc_channel.sv
// Top of the timer capture/compare channel: counter, pin edge detector and register.
// Assumes: a synchronous active-low reset and an asynchronous cap_pin.
module tcc_channel #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_tick,
    input  logic             cnt_stop,
    input  logic             mode_capture,
    input  logic [1:0]       edge_sel,
    input  logic             cap_pin,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    output logic [CNT_W-1:0] cnt_value,
    output logic             irq
);
    logic             advance;
    logic             counted;
    logic             edge_hit;
    logic [CNT_W-1:0] count;

    tcc_free_counter #(.W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (cnt_tick),
        .stop    (cnt_stop),
        .advance (advance),
        .counted (counted),
        .count   (count)
    );

    tcc_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (cap_pin),
        .sel   (edge_sel),
        .hit   (edge_hit)
    );

    tcc_cc_reg #(.W(CNT_W)) u_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_capture (mode_capture),
        .advance      (advance),
        .counted      (counted),
        .count        (count),
        .hit          (edge_hit),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .value        (rd_data),
        .irq          (irq)
    );

    assign cnt_value = count;
endmodule

// File: rtl/tcc_channel_chk.sv
// Port-level checker for tcc_channel, attached with bind.
module tcc_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_tick,
    input logic             cnt_stop,
    input logic             mode_capture,
    input logic [1:0]       edge_sel,
    input logic             wr_en,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] rd_data,
    input logic [CNT_W-1:0] cnt_value,
    input logic             irq
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && cnt_value == '0 && !irq));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && !cnt_stop) |=> cnt_value == $past(cnt_value) + ONE);

    assert_count_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_tick |=> $stable(cnt_value));

    assert_stop_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_stop |=> $stable(cnt_value));

    assert_match_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !mode_capture && !$past(wr_en)) |=> !irq);

    assert_write_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mode_capture) |=> rd_data == $past(wr_data));

    assert_compare_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !mode_capture) |=> $stable(rd_data));

    assert_reserved_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_capture && edge_sel == 2'b10 && !wr_en) |=> ($stable(rd_data) && !irq));
endmodule

bind tcc_channel tcc_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_tick     (cnt_tick),
    .cnt_stop     (cnt_stop),
    .mode_capture (mode_capture),
    .edge_sel     (edge_sel),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .cnt_value    (cnt_value),
    .irq          (irq)
);

// File: tb/tcc_channel_tb.sv
module tcc_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_tick = 1'b0;
    logic        cnt_stop = 1'b0;
    logic        mode_capture = 1'b0;
    logic [1:0]  edge_sel = 2'b01;
    logic        cap_pin = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [15:0] cnt_value;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tcc_channel dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cnt_stop(cnt_stop),
        .mode_capture(mode_capture), .edge_sel(edge_sel), .cap_pin(cap_pin),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .cnt_value(cnt_value), .irq(irq)
    );

    // Count interrupt pulses, sampled away from the active edge.
    always @(negedge clk) if (rst_n && irq) irq_seen++;

    typedef struct packed {
        logic [15:0] cmp;
        logic [16:0] ticks;
        logic [7:0]  exp_irq;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{16'd5,     17'd10,    8'd1},
        '{16'd0,     17'd10,    8'd0},
        '{16'd9,     17'd9,     8'd0},
        '{16'd9,     17'd10,    8'd1},
        '{16'd0,     17'd65537, 8'd1},
        '{16'hFFFF,  17'd65537, 8'd1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        cap_pin = 1'b0; cnt_tick = 1'b0; cnt_stop = 1'b0; wr_en = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        irq_seen = 0;
    endtask

    task automatic write_reg(input logic [15:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        cnt_tick = 1'b1;
        repeat (n) @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    // Capture one rising then one falling pin change with the given edge code.
    task automatic cap_case(input logic [1:0] sel, input bit want_rise, input bit want_fall,
                            input string req);
        int exp_irq;
        do_reset();
        mode_capture = 1'b1; edge_sel = sel;
        run_ticks(7);
        cap_pin = 1'b1;
        repeat (4) @(negedge clk);
        chk({req, " rise value"}, rd_data, want_rise ? 32'd7 : 32'd0);
        run_ticks(2);
        cap_pin = 1'b0;
        repeat (4) @(negedge clk);
        chk({req, " fall value"}, rd_data, want_fall ? 32'd9 : (want_rise ? 32'd7 : 32'd0));
        exp_irq = int'(want_rise) + int'(want_fall);
        chk({req, " R8 irq count"}, irq_seen, exp_irq);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reg", rd_data, 0);
        chk("R1 cnt", cnt_value, 0);
        chk("R1 irq", irq, 0);

        // Table walk: compare value, tick count, expected pulses (R2 R4 R5).
        foreach (VECS[i]) begin
            do_reset();
            mode_capture = 1'b0;
            write_reg(VECS[i].cmp);
            irq_seen = 0;
            run_ticks(int'(VECS[i].ticks));
            repeat (2) @(negedge clk);
            chk("R4 R5 irq count", irq_seen, VECS[i].exp_irq);
            chk("R2 final count", cnt_value, VECS[i].ticks % 17'h10000);
        end

        // R3: stop holds the counter.
        do_reset();
        run_ticks(4);
        cnt_stop = 1'b1; cnt_tick = 1'b1;
        repeat (5) @(negedge clk);
        cnt_stop = 1'b0; cnt_tick = 1'b0;
        chk("R3 stop hold", cnt_value, 4);

        // R6: rewrite while running, value held between writes.
        do_reset();
        mode_capture = 1'b0;
        write_reg(16'd2);
        cnt_tick = 1'b1;
        repeat (3) @(negedge clk);
        write_reg(16'd10);
        repeat (8) @(negedge clk);
        cnt_tick = 1'b0;
        @(negedge clk);
        chk("R6 reg held", rd_data, 10);
        chk("R6 irq after rewrite", irq_seen, 2);
        chk("R6 count", cnt_value, 12);

        // R7 / R8: edge codes.
        cap_case(2'b01, 1'b1, 1'b0, "R7 rise");
        cap_case(2'b00, 1'b0, 1'b1, "R7 fall");
        cap_case(2'b11, 1'b1, 1'b1, "R7 both");
        cap_case(2'b10, 1'b0, 1'b0, "R7 reserved");

        // R9: write strobe on the capture clock.
        do_reset();
        mode_capture = 1'b1; edge_sel = 2'b01;
        run_ticks(7);
        cap_pin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        write_reg(16'hABCD);
        @(negedge clk);
        chk("R9 capture wins", rd_data, 7);
        write_reg(16'h1234);
        chk("R6 write in capture mode", rd_data, 16'h1234);

        // R10: compare mode ignores pin edges.
        do_reset();
        mode_capture = 1'b0; edge_sel = 2'b11;
        write_reg(16'd5);
        run_ticks(3);
        cap_pin = 1'b1;
        repeat (4) @(negedge clk);
        cap_pin = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 compare ignores pin reg", rd_data, 5);
        chk("R10 compare ignores pin irq", irq_seen, 0);

        // R10: capture mode ignores counter matches.
        do_reset();
        mode_capture = 1'b1; edge_sel = 2'b01;
        write_reg(16'd3);
        run_ticks(8);
        @(negedge clk);
        chk("R10 capture no match irq", irq_seen, 0);
        chk("R10 capture reg kept", rd_data, 3);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (199000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule